// File: doc/BRIEF.md
# Dual-Channel Converter Register Controller

This block keeps the digital state behind a two-channel digital-to-analog converter. Each channel has a staging register and an output register that holds the active code. A serial front end, which is not part of the block, hands over decoded write requests. Each request carries a command, a channel mask and a 16-bit data field, and it is framed by a busy level and a one-cycle completion strobe.

Two board pins act on the register state. A low level on the load pin moves staged codes into the output registers. This lets both channels change on the same clock edge. The load pin can also be tied low, and then the outputs follow every staged write. A falling edge on the clear pin forces every code to zero scale. Each pin passes through a two-flop synchronizer first.

The block also keeps a sleep flag for each channel and a single enable bit for the on-chip voltage reference.

Top module: `dual_dac_regs`

## Requirements
- R1: When reset is released, every output code is zero, every sleep flag is 0 and the reference enable is 0.
- R2: A write with `wr_cmd`=0 (stage) loads code `wr_data[15:16-DW]` into the staging register of each channel whose bit in `wr_sel` is 1 (bit 0 is channel A, bit 1 is channel B) and marks that channel pending. The output codes do not change while `load_n` is high.
- R3: While the synchronized `load_n` is low and the synchronized `clr_n` is high, every pending channel copies its staging register to its output register on the same edge, and its pending mark is cleared. A channel that is not pending keeps its output. The output changes on the third rising edge after `load_n` falls.
- R4: When `load_n` is held low, a staged write reaches the output register without any load pulse.
- R5: A write with `wr_cmd`=1 (commit) loads both the staging and the output register of each selected channel, whatever the level of `load_n`.
- R6: With `wr_sel`=2'b11, one write updates both channels, and a later load moves both pending codes together. With `wr_sel`=2'b00, a write changes nothing.
- R7: Only the top DW bits of `wr_data` form the code. The low 16-DW bits never reach an output code.
- R8: A falling edge on `clr_n` sets every staging and every output register to zero and drops all pending marks. A later load pulse therefore leaves the outputs at zero until a new valid write arrives.
- R9: While the synchronized `clr_n` is low, load requests have no effect. A write accepted during that time is still staged, and it moves to the output at the first load after `clr_n` returns high.
- R10: If the clear edge is seen while `wr_active` is high, that write is aborted. Its completion strobe changes no register, and the abort lasts until `wr_active` falls.
- R11: A write with `wr_cmd`=2 (sleep) sets the sleep flag of each selected channel to `wr_data[0]`. A clear does not affect the sleep flags.
- R12: A write with `wr_cmd`=3 (reference) sets `ref_en` to `wr_data[0]`. Nothing else changes `ref_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_active | input | 1 | High while the front end is receiving a write |
| wr_valid | input | 1 | One-cycle strobe that marks a completed write |
| wr_cmd | input | 2 | Command: 0 stage, 1 commit, 2 sleep, 3 reference |
| wr_sel | input | NCH | Channel mask; bit 0 is channel A |
| wr_data | input | FW | Data field; the code is left-aligned |
| load_n | input | 1 | Asynchronous load pin, active low |
| clr_n | input | 1 | Asynchronous clear pin, acts on its falling edge |
| dac_code | output | NCH*DW | Output codes; channel A in the low DW bits |
| pwr_down | output | NCH | Sleep flag for each channel |
| ref_en | output | 1 | Reference enable |

## Verification
The bound checker checks the following on every cycle:
- The outputs are zero after reset and after each detected clear edge.
- The output codes hold while the load pin is inactive and no write completes.
- The output codes hold while the clear pin is held low.
- An aborted completion strobe changes nothing.
- The sleep flags and the reference enable move only on a completed write.

Some behaviour only the bench scenarios can show:
- The synchronizer latency of the load pin.
- Pending data that is dropped by a clear.
- A write staged during clear that surfaces only at a later load.
- The left alignment of the code.
- The load pin tied low.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  typedef enum logic [1:0] {
    CMD_STAGE  = 2'd0,
    CMD_COMMIT = 2'd1,
    CMD_SLEEP  = 2'd2,
    CMD_REF    = 2'd3
  } dac_cmd_e;
endpackage

// File: rtl/dual_dac_sync.sv
// Multi-flop synchronizer for an idle-high pin, with falling-edge detect.
module dual_dac_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '1;
      prev_q <= 1'b1;
    end else begin
      shreg  <= {shreg[STAGES-2:0], pin_async};
      prev_q <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign fall  = prev_q & ~shreg[STAGES-1];
endmodule

// File: rtl/dual_dac_chan.sv
// One channel: staging register, output register, pending mark, sleep flag.
module dual_dac_chan #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_fall,
  input  logic          wr_stage,
  input  logic          wr_commit,
  input  logic [DW-1:0] code,
  input  logic          xfer,
  input  logic          pd_set,
  input  logic          pd_val,
  output logic [DW-1:0] dac,
  output logic          pd
);
  logic [DW-1:0] stage_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      dac     <= '0;
      pend_q  <= 1'b0;
      pd      <= 1'b0;
    end else begin
      if (clr_fall) begin
        stage_q <= '0;
        dac     <= '0;
        pend_q  <= 1'b0;
      end else if (wr_commit) begin
        stage_q <= code;
        dac     <= code;
        pend_q  <= 1'b0;
      end else if (wr_stage) begin
        stage_q <= code;
        pend_q  <= 1'b1;
      end else if (xfer && pend_q) begin
        dac     <= stage_q;
        pend_q  <= 1'b0;
      end
      if (pd_set) pd <= pd_val;
    end
  end
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
  import dual_dac_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 12,
  parameter int FW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_active,
  input  logic              wr_valid,
  input  logic [1:0]        wr_cmd,
  input  logic [NCH-1:0]    wr_sel,
  input  logic [FW-1:0]     wr_data,
  input  logic              load_n,
  input  logic              clr_n,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    pwr_down,
  output logic              ref_en
);
  localparam int SYNC_STAGES = 2;

  logic          clr_lvl, clr_fall, load_lvl, load_fall_unused;
  logic          abort_q, write_ok, xfer;
  logic [DW-1:0] code;
  dac_cmd_e      cmd;
  logic          unused_lsbs;

  dual_dac_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .rst(rst), .pin_async(clr_n), .level(clr_lvl), .fall(clr_fall)
  );
  dual_dac_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
    .clk(clk), .rst(rst), .pin_async(load_n), .level(load_lvl), .fall(load_fall_unused)
  );

  // Abort lasts from the clear edge until the write frame ends.
  always_ff @(posedge clk) begin
    if (rst)                        abort_q <= 1'b0;
    else if (clr_fall && wr_active) abort_q <= 1'b1;
    else if (!wr_active)            abort_q <= 1'b0;
  end

  assign cmd         = dac_cmd_e'(wr_cmd);
  assign write_ok    = wr_valid & wr_active & ~abort_q & ~clr_fall;
  assign xfer        = ~load_lvl & clr_lvl;
  assign code        = wr_data[FW-1 -: DW];
  assign unused_lsbs = ^wr_data;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dual_dac_chan #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .clr_fall (clr_fall),
      .wr_stage (write_ok && cmd == CMD_STAGE  && wr_sel[c]),
      .wr_commit(write_ok && cmd == CMD_COMMIT && wr_sel[c]),
      .code     (code),
      .xfer     (xfer),
      .pd_set   (write_ok && cmd == CMD_SLEEP  && wr_sel[c]),
      .pd_val   (wr_data[0]),
      .dac      (dac_code[c*DW +: DW]),
      .pd       (pwr_down[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                            ref_en <= 1'b0;
    else if (write_ok && cmd == CMD_REF) ref_en <= wr_data[0];
  end
endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk #(
  parameter int NCH = 2,
  parameter int DW  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              clr_s,
  input logic              clr_fall,
  input logic              load_s,
  input logic              abort_q,
  input logic [NCH*DW-1:0] dac_code,
  input logic [NCH-1:0]    pwr_down,
  input logic              ref_en
);
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (dac_code == '0 && pwr_down == '0 && !ref_en));

  p_hold_no_load_r2: assert property (@(posedge clk) disable iff (rst)
    (load_s && !wr_valid && !clr_fall) |=> $stable(dac_code));

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr_fall |=> dac_code == '0);

  p_load_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr_s && !clr_fall && !wr_valid) |=> $stable(dac_code));

  p_abort_no_change_r10: assert property (@(posedge clk) disable iff (rst)
    (abort_q && wr_valid) |=> ($stable(dac_code) && $stable(pwr_down) && $stable(ref_en)));

  p_sleep_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(pwr_down));

  p_ref_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(ref_en));
endmodule

bind dual_dac_regs dual_dac_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .clr_s(clr_lvl), .clr_fall(clr_fall),
  .load_s(load_lvl), .abort_q(abort_q), .dac_code(dac_code), .pwr_down(pwr_down),
  .ref_en(ref_en)
);

// File: tb/sim_dual_dac_regs.sv
module sim_dual_dac_regs;
  localparam int DW = 12;
  localparam int VW = 46;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_active = 1'b0, wr_valid = 1'b0;
  logic [1:0]  wr_cmd = '0, wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        load_n = 1'b1, clr_n = 1'b1;
  logic [2*DW-1:0] dac_code;
  logic [1:0]  pwr_down;
  logic        ref_en;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dual_dac_regs #(.NCH(2), .DW(DW), .FW(16)) u0 (
    .clk(clk), .rst(rst), .wr_active(wr_active), .wr_valid(wr_valid), .wr_cmd(wr_cmd),
    .wr_sel(wr_sel), .wr_data(wr_data), .load_n(load_n), .clr_n(clr_n),
    .dac_code(dac_code), .pwr_down(pwr_down), .ref_en(ref_en)
  );

  // {do_write, do_load, cmd, sel, data, expected A, expected B}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 2'b01, 16'h1230, 12'h000, 12'h000},  // R2
    {1'b1, 1'b0, 2'd0, 2'b10, 16'hABC0, 12'h000, 12'h000},  // R2
    {1'b0, 1'b1, 2'd0, 2'b00, 16'h0000, 12'h123, 12'hABC},  // R3
    {1'b1, 1'b0, 2'd1, 2'b01, 16'h5555, 12'h555, 12'hABC},  // R5 R7
    {1'b1, 1'b1, 2'd0, 2'b11, 16'hFFF0, 12'hFFF, 12'hFFF},  // R6
    {1'b1, 1'b0, 2'd1, 2'b10, 16'h000F, 12'hFFF, 12'h000},  // R7
    {1'b0, 1'b1, 2'd0, 2'b00, 16'h0000, 12'hFFF, 12'h000},  // R3 no pending
    {1'b1, 1'b1, 2'd1, 2'b00, 16'h1234, 12'hFFF, 12'h000}   // R6 empty mask
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] c, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_active = 1'b1; wr_cmd = c; wr_sel = s; wr_data = d;
    cycles(2);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_active = 1'b0;
    cycles(2);
  endtask

  task automatic do_load();
    @(negedge clk);
    load_n = 1'b0;
    cycles(3);
    load_n = 1'b1;
    cycles(4);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_n = 1'b0;
    cycles(4);
    clr_n = 1'b1;
    cycles(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(1);
    check("R1 codes", 32'(dac_code), 32'h0);
    check("R1 sleep", 32'(pwr_down), 32'h0);
    check("R1 ref", 32'(ref_en), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      if (v[45]) do_write(v[43:42], v[41:40], v[39:24]);
      if (v[44]) do_load();
      cycles(2);
      check($sformatf("R2/R3/R5/R6/R7 vec%0d A", i), 32'(dac_code[DW-1:0]), 32'(v[23:12]));
      check($sformatf("R2/R3/R5/R6/R7 vec%0d B", i), 32'(dac_code[2*DW-1:DW]), 32'(v[11:0]));
    end

    // R3 latency: output changes on the third rising edge after load_n falls
    do_write(2'd0, 2'b01, 16'h2220);
    @(negedge clk);
    load_n = 1'b0;
    cycles(2);
    check("R3 before third edge", 32'(dac_code[DW-1:0]), 32'hFFF);
    cycles(1);
    check("R3 at third edge", 32'(dac_code[DW-1:0]), 32'h222);
    load_n = 1'b1;
    cycles(4);

    // R12 reference enable
    do_write(2'd3, 2'b00, 16'h0001);
    check("R12 ref on", 32'(ref_en), 32'h1);
    do_write(2'd3, 2'b11, 16'h0000);
    check("R12 ref off", 32'(ref_en), 32'h0);

    // R11 sleep flag on channel A
    do_write(2'd2, 2'b01, 16'h0001);
    check("R11 sleep A", 32'(pwr_down), 32'h1);

    // R4 load tied low
    @(negedge clk);
    load_n = 1'b0;
    cycles(4);
    do_write(2'd0, 2'b01, 16'h7770);
    cycles(1);
    check("R4 follow A", 32'(dac_code[DW-1:0]), 32'h777);
    load_n = 1'b1;
    cycles(4);

    // R8 clear zeroes everything and drops pending data
    do_write(2'd0, 2'b10, 16'h4440);
    do_clear();
    check("R8 codes zero", 32'(dac_code), 32'h0);
    check("R11 sleep kept over clear", 32'(pwr_down), 32'h1);
    do_load();
    check("R8 pending dropped", 32'(dac_code), 32'h0);

    // R9 load ignored while clear held low
    @(negedge clk);
    clr_n = 1'b0;
    cycles(4);
    do_write(2'd0, 2'b01, 16'h9990);
    do_load();
    check("R9 load masked", 32'(dac_code[DW-1:0]), 32'h0);
    @(negedge clk);
    clr_n = 1'b1;
    cycles(4);
    do_load();
    check("R9 staged write lands", 32'(dac_code[DW-1:0]), 32'h999);

    // R10 clear during a write aborts it
    @(negedge clk);
    wr_active = 1'b1; wr_cmd = 2'd1; wr_sel = 2'b01; wr_data = 16'h3330;
    cycles(1);
    clr_n = 1'b0;
    cycles(4);
    clr_n = 1'b1;
    cycles(4);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_active = 1'b0;
    cycles(3);
    check("R10 aborted write", 32'(dac_code[DW-1:0]), 32'h0);
    do_write(2'd1, 2'b01, 16'h3330);
    check("R10 next write accepted", 32'(dac_code[DW-1:0]), 32'h333);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule